// File: doc/BRIEF.md
# Time-Base Interval Timer

This block is a free-running 24-bit down counter used as a prescaler. Other peripherals take clock taps from it. Software programs an interval through an 8-bit control register. Each time the counter's low bits for the chosen interval wrap from all-zero to all-ones, an interrupt flag is raised. If the interrupt enable is also set, the block drives an interrupt request line.

Several events force the counter back to all-ones:

- a software clear;
- a stopped source clock;
- entry into stop mode;
- a switch to a sub-clock mode;
- a power-on clear;
- a low-voltage reset.

Each reload emits a one-cycle reload pulse. When a dependent watchdog is set to run from this counter, each reload is also passed on to it as a watchdog clear.

Top module: `tick_base_timer`

## Requirements
- R1: After synchronous reset, the counter holds all-ones, so the taps read 4'hF. The control register reads 8'h00, and irq, reload_pulse and wdt_clr are 0.
- R2: While no reload cause is present, the counter decrements by one on each clock where tick_en is 1. It holds its value when tick_en is 0.
- R3: Writing a control byte with bit0 = 1 reloads the counter to all-ones and counting continues downward. Bit0 always reads as 0.
- R4: Each of the following reloads the counter to all-ones in the cycle it is high: src_stopped, enter_stop, enter_sub, por_clr and lvr_clr. src_stopped keeps the counter at all-ones for as long as it stays high.
- R5: With select code c (bits 4:1), the flag (bit7) sets on a tick taken while the counter's low c+9 bits are all zero. The first set therefore comes 2^(c+9) ticks after a reload, and it repeats every 2^(c+9) ticks after that.
- R6: The control register reads bit7 flag, bit6 interrupt enable, bit5 constant 0, bits 4:1 select code and bit0 constant 0. A write updates enable and select from the written byte.
- R7: A write with bit7 = 0 clears the flag. A write with bit7 = 1 leaves the flag unchanged. An interval event in the same cycle as a write of 0 leaves the flag set.
- R8: If any reload cause and an interval tick fall in the same cycle, the reload wins and the flag is not set by that tick.
- R9: irq is 1 exactly when both the flag and the interrupt enable read as 1.
- R10: reload_pulse is 1 for each cycle after a clock edge at which a reload cause was present. wdt_clr equals reload_pulse when wdt_link is 1 and is 0 otherwise.
- R11: taps always shows the low 4 bits of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for this cycle |
| src_stopped | input | 1 | Selected source clock is stopped; holds the counter reloaded |
| enter_stop | input | 1 | Pulse on entry into stop mode |
| enter_sub | input | 1 | Pulse on change from a main-clock mode to a sub-clock mode |
| por_clr | input | 1 | Power-on clear request |
| lvr_clr | input | 1 | Low-voltage reset clear request |
| wdt_link | input | 1 | Watchdog uses this counter as its clock |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| irq | output | 1 | Interrupt request |
| taps | output | 4 | Low counter bits for other peripherals |
| reload_pulse | output | 1 | One cycle per reload |
| wdt_clr | output | 1 | Clear to the dependent watchdog |

## Verification
Every result of this block appears one clock after the edge that samples its cause. This applies to the counter value on the taps, the flag, enable and select in rd_data, irq, reload_pulse and wdt_clr. The bench drives inputs on the falling edge and updates its reference state at the rising edge. It compares the outputs on the next falling edge, so each check falls exactly one register stage after its stimulus. Directed checks count ticks from a reload so they can sample the flag at tick 2^(c+9) − 1 and at tick 2^(c+9). The clear-versus-event test places the reload on exactly that tick.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned FLAG_POS = 7;
  localparam int unsigned IEN_POS  = 6;
  localparam int unsigned SEL_LSB  = 1;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned CLR_POS  = 0;
  localparam int unsigned N_CAUSE  = 6;
  localparam int unsigned CS_SW    = 0;
  localparam int unsigned CS_STOPD = 1;
  localparam int unsigned CS_STOPM = 2;
  localparam int unsigned CS_SUB   = 3;
  localparam int unsigned CS_POR   = 4;
  localparam int unsigned CS_LVR   = 5;
endpackage

// File: rtl/tbt_reload_merge.sv
module tbt_reload_merge #(
  parameter int unsigned NC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] cause,
  input  logic          wdt_link,
  output logic          reload,
  output logic          reload_pulse,
  output logic          wdt_clr
);
  assign reload = |cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_pulse <= 1'b0;
      wdt_clr      <= 1'b0;
    end else begin
      reload_pulse <= reload;
      wdt_clr      <= reload & wdt_link;
    end
  end

  AST_WDT_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
    !wdt_link |=> !wdt_clr); // R10
endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || reload)
      cnt <= '1;
    else if (tick)
      cnt <= cnt - ONE;
  end

  AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == '1)); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (!reload && tick) |=> (cnt == $past(cnt) - ONE)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!reload && !tick) |=> $stable(cnt)); // R2
endmodule

// File: rtl/tbt_interval.sv
module tbt_interval #(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned SEL_BASE = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic             reload,
  output logic             evt
);
  localparam int unsigned N_SEL = 1 << SEL_W;
  logic [N_SEL-1:0] low_zero;

  for (genvar i = 0; i < N_SEL; i++) begin : g_tap
    assign low_zero[i] = ~|cnt[SEL_BASE+i:0];
  end

  assign evt = tick & ~reload & low_zero[sel];
endmodule

// File: rtl/tbt_ctrl.sv
module tbt_ctrl
  import tbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              evt,
  output logic [SEL_W-1:0]  sel,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq
);
  logic             flag_q, ien_q, flag_n, ien_n;
  logic [SEL_W-1:0] sel_n;
  logic             unused_wr_bits;

  assign unused_wr_bits = wr_data[5] | wr_data[CLR_POS];

  always_comb begin
    flag_n = flag_q;
    ien_n  = ien_q;
    sel_n  = sel;
    if (wr_en) begin
      if (!wr_data[FLAG_POS]) flag_n = 1'b0;
      ien_n = wr_data[IEN_POS];
      sel_n = wr_data[SEL_LSB +: SEL_W];
    end
    if (evt) flag_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      sel    <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_n;
      ien_q  <= ien_n;
      sel    <= sel_n;
      irq    <= flag_n & ien_n;
    end
  end

  assign rd_data = {flag_q, ien_q, 1'b0, sel, 1'b0};

  AST_FLAG_W1_NOSET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[FLAG_POS] && !flag_q && !evt) |=> !flag_q); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> ien_q); // R9
endmodule

// File: rtl/tick_base_timer.sv
module tick_base_timer
  import tbt_pkg::*;
#(
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned SEL_BASE = 8,
  parameter int unsigned TAP_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              src_stopped,
  input  logic              enter_stop,
  input  logic              enter_sub,
  input  logic              por_clr,
  input  logic              lvr_clr,
  input  logic              wdt_link,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq,
  output logic [TAP_W-1:0]  taps,
  output logic              reload_pulse,
  output logic              wdt_clr
);
  logic [N_CAUSE-1:0] cause;
  logic               reload, evt;
  logic [CNT_W-1:0]   cnt;
  logic [SEL_W-1:0]   sel;

  always_comb begin
    cause           = '0;
    cause[CS_SW]    = wr_en & wr_data[CLR_POS];
    cause[CS_STOPD] = src_stopped;
    cause[CS_STOPM] = enter_stop;
    cause[CS_SUB]   = enter_sub;
    cause[CS_POR]   = por_clr;
    cause[CS_LVR]   = lvr_clr;
  end

  tbt_reload_merge #(.NC(N_CAUSE)) u_merge (
    .clk(clk), .rst(rst), .cause(cause), .wdt_link(wdt_link),
    .reload(reload), .reload_pulse(reload_pulse), .wdt_clr(wdt_clr)
  );

  tbt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .reload(reload), .tick(tick_en), .cnt(cnt)
  );

  tbt_interval #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SEL_BASE(SEL_BASE)) u_int (
    .cnt(cnt), .sel(sel), .tick(tick_en), .reload(reload), .evt(evt)
  );

  tbt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .evt(evt),
    .sel(sel), .rd_data(rd_data), .irq(irq)
  );

  assign taps = cnt[TAP_W-1:0];

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (reload && !rd_data[FLAG_POS]) |=> !rd_data[FLAG_POS]); // R8
  AST_WDT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |-> reload_pulse); // R10
  AST_TAPS_RELOADED: assert property (@(posedge clk) disable iff (rst)
    reload_pulse |-> (taps == '1)); // R3
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data[CLR_POS] == 1'b0) && (rd_data[5] == 1'b0)); // R6
endmodule

// File: tb/tb_tick_base_timer.sv
module tb_tick_base_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, src_stopped = 1'b0, enter_stop = 1'b0, enter_sub = 1'b0;
  logic       por_clr = 1'b0, lvr_clr = 1'b0, wdt_link = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, reload_pulse, wdt_clr;
  logic [3:0] taps;

  int errors = 0;
  int checks = 0;
  logic [23:0] m_cnt = 24'hFFFFFF;
  logic        m_flag = 0, m_ie = 0, m_irq = 0, m_rp = 0, m_wc = 0;
  logic [3:0]  m_sel = 0;

  always #2.5 clk = ~clk;

  tick_base_timer dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .src_stopped(src_stopped),
    .enter_stop(enter_stop), .enter_sub(enter_sub), .por_clr(por_clr),
    .lvr_clr(lvr_clr), .wdt_link(wdt_link), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .taps(taps), .reload_pulse(reload_pulse),
    .wdt_clr(wdt_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic rl, ev;
    logic [23:0] mask;
    if (rst) begin
      m_cnt = 24'hFFFFFF; m_flag = 0; m_ie = 0; m_sel = 0; m_irq = 0; m_rp = 0; m_wc = 0;
      return;
    end
    rl = (wr_en && wr_data[0]) || src_stopped || enter_stop || enter_sub || por_clr || lvr_clr;
    mask = 24'((32'd1 << (int'(m_sel) + 9)) - 1);
    ev = tick_en && !rl && ((m_cnt & mask) == 24'd0);
    if (rl) m_cnt = 24'hFFFFFF;
    else if (tick_en) m_cnt = m_cnt - 24'd1;
    if (wr_en) begin
      if (!wr_data[7]) m_flag = 0;
      m_ie = wr_data[6];
      m_sel = wr_data[4:1];
    end
    if (ev) m_flag = 1;
    m_irq = m_flag & m_ie;
    m_rp = rl;
    m_wc = rl & wdt_link;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(taps == m_cnt[3:0], "R11/R2 taps", 32'(taps), 32'(m_cnt[3:0]));
    chk(rd_data == {m_flag, m_ie, 1'b0, m_sel, 1'b0}, "R6 rd_data", 32'(rd_data),
        32'({m_flag, m_ie, 1'b0, m_sel, 1'b0}));
    chk(irq == m_irq, "R9 irq", 32'(irq), 32'(m_irq));
    chk(reload_pulse == m_rp, "R10 reload_pulse", 32'(reload_pulse), 32'(m_rp));
    chk(wdt_clr == m_wc, "R10 wdt_clr", 32'(wdt_clr), 32'(m_wc));
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = 8'h00; src_stopped = 0; enter_stop = 0; enter_sub = 0;
    por_clr = 0; lvr_clr = 0;
  endtask

  task automatic write_ctrl(input logic [7:0] d);
    wr_en = 1; wr_data = d; cycle(); wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int stop_left;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    @(negedge clk);
    cycle(); cycle();
    rst = 0;
    // R1: reset state
    chk(taps == 4'hF, "R1 taps", 32'(taps), 32'hF);
    chk(rd_data == 8'h00, "R1 rd_data", 32'(rd_data), 0);
    chk(!irq && !reload_pulse && !wdt_clr, "R1 outputs", 32'({irq, reload_pulse, wdt_clr}), 0);

    // R5: first event exactly 512 ticks after reset with code 0
    tick_en = 1;
    repeat (511) cycle();
    chk(rd_data[7] == 0, "R5 flag before 512 ticks", 32'(rd_data[7]), 0);
    cycle();
    chk(rd_data[7] == 1, "R5 flag at 512 ticks", 32'(rd_data[7]), 1);
    chk(taps == 4'hF, "R5 wrapped taps", 32'(taps), 32'hF);

    // R9/R7: enable with flag-bit 1 keeps flag, irq rises
    write_ctrl(8'hC0);
    chk(rd_data[7] && irq, "R9 irq on flag and enable", 32'(irq), 1);
    write_ctrl(8'h40);
    chk(!rd_data[7] && !irq, "R7 write 0 clears flag", 32'(rd_data[7]), 0);
    write_ctrl(8'hC0);
    chk(!rd_data[7], "R7 write 1 does not set flag", 32'(rd_data[7]), 0);

    // R3/R10: software clear with watchdog link
    wdt_link = 1;
    write_ctrl(8'h41);
    chk(taps == 4'hF && reload_pulse && wdt_clr, "R3 clear reload", 32'({taps, reload_pulse, wdt_clr}), 32'h3F);
    chk(rd_data[0] == 0, "R3 clear bit reads 0", 32'(rd_data[0]), 0);
    repeat (5) cycle();
    chk(taps == 4'hA, "R11 taps after 5 ticks", 32'(taps), 32'hA);
    tick_en = 0;
    repeat (3) cycle();
    chk(taps == 4'hA, "R2 hold without tick", 32'(taps), 32'hA);
    chk(!reload_pulse, "R10 pulse one cycle", 32'(reload_pulse), 0);

    // R8: reload on the event tick suppresses the flag
    tick_en = 1;
    write_ctrl(8'h41);
    repeat (511) cycle();
    enter_stop = 1; cycle(); enter_stop = 0;
    chk(!rd_data[7] && taps == 4'hF, "R8 clear wins over event", 32'(rd_data[7]), 0);
    chk(reload_pulse, "R4 stop entry reload", 32'(reload_pulse), 1);

    // R4: stopped source holds the counter
    wdt_link = 0;
    src_stopped = 1;
    for (int i = 0; i < 5; i++) begin
      cycle();
      chk(taps == 4'hF && reload_pulse && !wdt_clr, "R4 held while stopped", 32'(taps), 32'hF);
    end
    src_stopped = 0;
    repeat (3) cycle();
    enter_sub = 1; cycle(); enter_sub = 0;
    chk(taps == 4'hF, "R4 sub-mode reload", 32'(taps), 32'hF);
    repeat (3) cycle();
    por_clr = 1; cycle(); por_clr = 0;
    chk(taps == 4'hF, "R4 power-on reload", 32'(taps), 32'hF);
    repeat (3) cycle();
    lvr_clr = 1; cycle(); lvr_clr = 0;
    chk(taps == 4'hF, "R4 low-voltage reload", 32'(taps), 32'hF);

    // R5: code 1 gives 1024 ticks
    write_ctrl(8'h03);
    repeat (1023) cycle();
    chk(!rd_data[7], "R5 code1 before 1024", 32'(rd_data[7]), 0);
    cycle();
    chk(rd_data[7], "R5 code1 at 1024", 32'(rd_data[7]), 1);

    // R7: event on the same tick as a write of 0 leaves flag set
    write_ctrl(8'h41);
    repeat (511) cycle();
    wr_en = 1; wr_data = 8'h40; cycle(); idle_inputs();
    chk(rd_data[7], "R7 event beats write 0", 32'(rd_data[7]), 1);

    // random phase
    stop_left = 0;
    for (int n = 0; n < 30000; n++) begin
      idle_inputs();
      tick_en = ($urandom_range(0, 9) != 0);
      wdt_link = ($urandom_range(0, 3) != 0);
      if (stop_left > 0) begin src_stopped = 1; stop_left--; end
      else if ($urandom_range(0, 999) == 0) stop_left = $urandom_range(1, 6);
      enter_stop = ($urandom_range(0, 1499) == 0);
      enter_sub  = ($urandom_range(0, 1499) == 0);
      por_clr    = ($urandom_range(0, 1999) == 0);
      lvr_clr    = ($urandom_range(0, 1999) == 0);
      if ($urandom_range(0, 149) == 0) begin
        wr_en = 1;
        wr_data = 8'($urandom);
        wr_data[4:1] = 4'($urandom_range(0, 2));
        wr_data[0] = ($urandom_range(0, 3) == 0);
      end
      cycle();
    end
    idle_inputs();
    finish_run();
  end
endmodule